// File: doc/BRIEF.md
# Timestamped Command Queue

This block holds a short, fixed-depth line of register-write commands and releases them one at a time, strictly in arrival order. Each command carries an address, a data word and an optional 64-bit release time. The command at the front is released when it has no release time, or when the free-running local time presented on an input has reached or passed that release time. A front command that is still waiting holds back everything behind it, even commands whose own time has already come. One instance is placed per data stream.

The producer writes with a single push strobe and has no back-pressure. It is expected to watch the `full` and `level` outputs. A push that arrives while the queue is full is an overflow. The overflowing command is discarded, and the block enters a halted state that only a reset clears. The consumer side is a valid/ready port. A command is consumed in a cycle where `out_valid` and `out_ready` are both high. `out_valid` never drops and `out_addr`/`out_data` never change while the consumer stalls. The time comparison is registered. A command therefore appears one cycle after it becomes eligible, and there is one empty cycle after each hand-off.

Top module: `tcq_top`

## Requirements
- R1: When an untimed command (`in_timed`=0) is pushed into an empty queue at clock edge E, `out_valid` is low after E and is high after edge E+1, carrying that command's address and data. The value of `in_stamp` is ignored.
- R2: A timed command (`in_timed`=1) at the front is presented only when `now_time` is greater than or equal to its stamp. The comparison is unsigned over 64 bits, so a stamp equal to the time is due. `out_valid` rises one edge after the first cycle in which the front command is due.
- R3: Commands leave in push order. A waiting timed command at the front keeps `out_valid` low, even when a later command is already due.
- R4: A push (`in_valid`=1) in a cycle where `full` is high sets `halted` after that edge. The pushed command is discarded.
- R5: While `halted` is high, `out_valid` stays low, further pushes and `out_ready` change nothing (`level` is frozen), and `halted` stays high until `rst_n` is asserted low.
- R6: A command is consumed at an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, `out_valid`, `out_addr` and `out_data` hold. After each consumption, `out_valid` is low for at least one cycle.
- R7: `level` equals the number of stored commands. `full` is high exactly when `level` equals DEPTH.
- R8: After reset, `level` is 0, and `full`, `out_valid` and `halted` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the only way out of the halted state |
| now_time | input | 64 | Current local time, unsigned |
| in_valid | input | 1 | Push strobe for one command (no back-pressure) |
| in_timed | input | 1 | 1: command waits for `in_stamp`; 0: release as soon as it is at the front |
| in_stamp | input | 64 | Release time of the pushed command |
| in_addr | input | 16 | Register address of the pushed command |
| in_data | input | 32 | Register data of the pushed command |
| out_valid | output | 1 | Front command is due and presented |
| out_ready | input | 1 | Consumer accepts the presented command |
| out_addr | output | 16 | Address of the presented command |
| out_data | output | 32 | Data of the presented command |
| level | output | $clog2(DEPTH+1) | Number of stored commands |
| full | output | 1 | Queue holds DEPTH commands |
| halted | output | 1 | Sticky overflow fault |

## Verification
The bench builds the block with DEPTH=5. This is a non-power-of-two depth, so the read and write pointers must wrap explicitly at an index below their natural binary roll-over. It also means overflow is reached after only five pushes. Release times straddling the top bit of the 64-bit range (0x7FFF... against 0x8000...) expose a signed comparison. The equal-time case is included to pin down the "reached or passed" boundary.

// File: rtl/tcq_pkg.sv
package tcq_pkg;
  localparam int TIME_W = 64;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;

  typedef struct packed {
    logic              timed;
    logic [TIME_W-1:0] stamp;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } tcq_entry_t;
endpackage

// File: rtl/tcq_store.sv
module tcq_store
  import tcq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  tcq_entry_t    wr_entry,
  output tcq_entry_t    head,
  output logic [CW-1:0] level,
  output logic          empty,
  output logic          full
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  tcq_entry_t    slot [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) slot[wr_ptr] <= wr_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      unique case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = slot[rd_ptr];
  assign level = count;
  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
endmodule

// File: rtl/tcq_release.sv
module tcq_release
  import tcq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_present,
  input  tcq_entry_t        head,
  input  logic [TIME_W-1:0] now_time,
  input  logic              halt,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              fire
);
  logic due_c;
  logic elig_q;

  // Unsigned compare; registered so the 64-bit path ends in a flop.
  assign due_c = head_present && (!head.timed || (now_time >= head.stamp));

  always_ff @(posedge clk) begin
    if (!rst_n) elig_q <= 1'b0;
    else        elig_q <= due_c && !fire && !halt;
  end

  assign out_valid = elig_q;
  assign fire      = elig_q && out_ready;
endmodule

// File: rtl/tcq_fault.sv
module tcq_fault (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic full,
  output logic overflow_now,
  output logic halted
);
  assign overflow_now = in_valid && full && !halted;

  always_ff @(posedge clk) begin
    if (!rst_n) halted <= 1'b0;
    else        halted <= halted || overflow_now;
  end
endmodule

// File: rtl/tcq_top.sv
module tcq_top
  import tcq_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TIME_W-1:0] now_time,
  input  logic              in_valid,
  input  logic              in_timed,
  input  logic [TIME_W-1:0] in_stamp,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data,
  output logic [LVL_W-1:0]  level,
  output logic              full,
  output logic              halted
);
  tcq_entry_t wr_entry, head;
  logic       push, fire, empty, overflow_now;

  assign wr_entry = '{timed: in_timed, stamp: in_stamp, addr: in_addr, data: in_data};
  assign push     = in_valid && !full && !halted;

  tcq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .pop      (fire),
    .wr_entry (wr_entry),
    .head     (head),
    .level    (level),
    .empty    (empty),
    .full     (full)
  );

  tcq_release u_release (
    .clk          (clk),
    .rst_n        (rst_n),
    .head_present (!empty),
    .head         (head),
    .now_time     (now_time),
    .halt         (halted || overflow_now),
    .out_ready    (out_ready),
    .out_valid    (out_valid),
    .fire         (fire)
  );

  tcq_fault u_fault (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .full         (full),
    .overflow_now (overflow_now),
    .halted       (halted)
  );

  assign out_addr = head.addr;
  assign out_data = head.data;
endmodule

// File: rtl/tcq_checker.sv
module tcq_checker #(
  parameter int DEPTH = 8,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [63:0]      now_time,
  input logic             in_valid,
  input logic             out_valid,
  input logic             out_ready,
  input logic [15:0]      out_addr,
  input logic [31:0]      out_data,
  input logic [LVL_W-1:0] level,
  input logic             full,
  input logic             halted,
  input logic             head_timed,
  input logic [63:0]      head_stamp
);
  // R2: a presented timed command was due in the previous cycle
  a_r2_only_when_due: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!$past(head_timed) || ($past(now_time) >= $past(head_stamp))));

  // R4: a push into a full queue halts the block
  a_r4_overflow_halts: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && full && !halted) |=> halted);

  // R5: halt is sticky
  a_r5_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R5: nothing is issued while halted
  a_r5_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !out_valid);

  // R6: a stalled output holds
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !(in_valid && full)) |=>
      (out_valid && $stable(out_addr) && $stable(out_data)));

  // R6: a bubble follows every hand-off
  a_r6_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> !out_valid);

  // R7: level never exceeds depth, full tracks it
  a_r7_level: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= LVL_W'(DEPTH)) && (full == (level == LVL_W'(DEPTH))));
endmodule

bind tcq_top tcq_checker #(.DEPTH(DEPTH)) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .now_time   (now_time),
  .in_valid   (in_valid),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_addr   (out_addr),
  .out_data   (out_data),
  .level      (level),
  .full       (full),
  .halted     (halted),
  .head_timed (head.timed),
  .head_stamp (head.stamp)
);

// File: tb/tcq_top_tb.sv
module tcq_top_tb;
  localparam int DEPTH = 5;
  localparam int LW = $clog2(DEPTH + 1);
  localparam int ROWS = 6;
  // {timed, now, stamp, addr, data}
  localparam logic [176:0] VEC [ROWS] = '{
    {1'b0, 64'd0, 64'hFFFF_FFFF_FFFF_FFFF, 16'h0010, 32'hA000_0001},
    {1'b1, 64'd1000, 64'd999, 16'h0020, 32'hA000_0002},
    {1'b1, 64'd1000, 64'd1000, 16'h0030, 32'hA000_0003},
    {1'b1, 64'd1000, 64'd1001, 16'h0040, 32'hA000_0004},
    {1'b1, 64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF, 16'h0050, 32'hA000_0005},
    {1'b1, 64'h7FFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000, 16'h0060, 32'hA000_0006}
  };

  logic clk = 0, rst_n = 0;
  logic [63:0] now_time = '0, in_stamp = '0;
  logic in_valid = 0, in_timed = 0, out_ready = 0;
  logic [15:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic out_valid, full, halted;
  logic [15:0] out_addr;
  logic [31:0] out_data;
  logic [LW-1:0] level;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tcq_top #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .now_time(now_time), .in_valid(in_valid),
    .in_timed(in_timed), .in_stamp(in_stamp), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_data(out_data), .level(level), .full(full), .halted(halted)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic t, input logic [63:0] s, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1; in_timed = t; in_stamp = s; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic pop();
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R8 reset state
    chk("R8 level", 64'(level), 0);
    chk("R8 full", 64'(full), 0);
    chk("R8 out_valid", 64'(out_valid), 0);
    chk("R8 halted", 64'(halted), 0);

    // Vector walk: R1 untimed latency, R2 unsigned/equal boundary
    for (int i = 0; i < ROWS; i++) begin
      logic        t;
      logic [63:0] nw, st;
      logic [15:0] a;
      logic [31:0] d;
      {t, nw, st, a, d} = VEC[i];
      now_time = nw;
      push(t, st, a, d);
      chk(t ? "R2 not before compare" : "R1 latency", 64'(out_valid), 0);
      if (!t || nw >= st) begin
        @(negedge clk);
        chk(t ? "R2 due valid" : "R1 valid", 64'(out_valid), 1);
      end else begin
        repeat (3) begin
          @(negedge clk);
          chk("R2 early held", 64'(out_valid), 0);
        end
        now_time = st;
        @(negedge clk);
        chk("R2 valid at stamp", 64'(out_valid), 1);
      end
      chk("R1 R2 addr", 64'(out_addr), 64'(a));
      chk("R1 R2 data", 64'(out_data), 64'(d));
      pop();
      chk("R6 bubble after pop", 64'(out_valid), 0);
      chk("R7 level empty", 64'(level), 0);
    end

    // R3: waiting front blocks a due follower
    now_time = 64'd100;
    push(1'b1, 64'd200, 16'h0A0A, 32'h1111_1111);
    push(1'b0, 64'd0, 16'h0B0B, 32'h2222_2222);
    chk("R7 level two", 64'(level), 2);
    repeat (4) begin
      @(negedge clk);
      chk("R3 blocked", 64'(out_valid), 0);
    end
    now_time = 64'd200;
    @(negedge clk);
    chk("R3 first valid", 64'(out_valid), 1);
    chk("R3 first addr", 64'(out_addr), 64'h0A0A);
    pop();
    chk("R6 bubble", 64'(out_valid), 0);
    @(negedge clk);
    chk("R3 second valid", 64'(out_valid), 1);
    chk("R3 second addr", 64'(out_addr), 64'h0B0B);
    pop();

    // R6 stall holds output
    push(1'b0, 64'd0, 16'h0C0C, 32'h3333_3333);
    @(negedge clk);
    repeat (3) begin
      @(negedge clk);
      chk("R6 stall valid", 64'(out_valid), 1);
      chk("R6 stall data", 64'(out_data), 64'h3333_3333);
    end
    pop();
    chk("R6 consumed", 64'(level), 0);

    // R7 fill, R4 overflow, R5 halted
    now_time = 64'd0;
    for (int k = 0; k < DEPTH; k++) push(1'b0, 64'd0, 16'(k), 32'(k));
    chk("R7 level full", 64'(level), DEPTH);
    chk("R7 full flag", 64'(full), 1);
    chk("R4 not yet halted", 64'(halted), 0);
    push(1'b0, 64'd0, 16'hDEAD, 32'hDEAD);
    chk("R4 halted", 64'(halted), 1);
    chk("R5 no valid", 64'(out_valid), 0);
    chk("R4 discarded", 64'(level), DEPTH);
    push(1'b0, 64'd0, 16'hBEEF, 32'hBEEF);
    out_ready = 1;
    repeat (2) begin
      @(negedge clk);
      chk("R5 no issue", 64'(out_valid), 0);
    end
    out_ready = 0;
    chk("R5 level frozen", 64'(level), DEPTH);
    chk("R5 sticky", 64'(halted), 1);
    do_reset();
    chk("R5 reset clears", 64'(halted), 0);
    chk("R8 level after reset", 64'(level), 0);
    push(1'b0, 64'd0, 16'h0F0F, 32'h4444_4444);
    @(negedge clk);
    chk("R1 after recovery", 64'(out_valid), 1);
    chk("R1 recovery data", 64'(out_data), 64'h4444_4444);
    pop();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule